// File: doc/BRIEF.md
# Complementary PWM Sequencer with Fault Retrigger

This block drives two complementary PWM outputs from one phase sequencer. Each period is split into four timed sub-phases that always follow the same order: a first dead time, the on time of output 0, a second dead time, and the on time of output 1. Every sub-phase has its own programmable length in clock cycles. The block is meant to sit next to a half-bridge gate driver, where the dead times keep both switches off during each hand-over.

Two active-high fault inputs each guard one half of the period. Fault A guards the dead-time-0 / on-time-0 half, and fault B guards the dead-time-1 / on-time-1 half. When a fault is seen in the half it guards, that half is cut short. The sequencer then runs the opposite dead-time / on-time pair in full, whatever the fault does in the meantime. After that it parks with both outputs off until the fault input is released, and then picks up the normal sequence again.

Top module: `cpwm_fault_seq`

## Requirements
- R1: The `phase` output encodes the sequencer state as follows: 0 idle, 1 dead time 0 (DT0), 2 on time 0 (ON0), 3 dead time 1 (DT1), 4 on time 1 (ON1), 5 hold after fault A, 6 hold after fault B. With no faults the phases repeat in the order DT0, ON0, DT1, ON1, DT0.
- R2: Each timed phase lasts max(L,1) clock cycles, where L is its 12-bit length input. A length of zero gives a one-cycle phase.
- R3: All four lengths are captured together on every entry into DT0. A change on the length inputs has no effect on the phases until the next DT0 entry.
- R4: `drv0` is high only in ON0, and `drv1` is high only in ON1. The two are never high together, and both are low in dead times, hold states and idle.
- R5: If `flt_a` is high while the phase is DT0 or ON0, the phase changes to DT1 on the third rising edge after `flt_a` rises (two synchronizer flops plus the state register). When the phase was ON0, `drv0` drops at that same edge.
- R6: Once a fault-A forced DT1 and ON1 pair has started, both phases run their full programmed lengths. This holds even if `flt_a` is released during the pair, and `flt_b` is ignored throughout the pair.
- R7: After the forced ON1, the phase is 5 (hold A) for at least one cycle. It stays there while the synchronized `flt_a` is high, and moves to DT0 on the third edge after `flt_a` falls.
- R8: `flt_a` has no effect while the phase is DT1 or ON1 of a normal period.
- R9: If `flt_b` is high while the phase is DT1 or ON1 of a normal period, the phase changes to DT0 on the third rising edge after `flt_b` rises. The forced DT0 and ON0 then run their full lengths, and `flt_a` is ignored throughout this pair.
- R10: After the forced ON0, the phase is 6 (hold B) for at least one cycle. It stays there while the synchronized `flt_b` is high, and moves to DT1 on the third edge after `flt_b` falls.
- R11: `flt_b` has no effect while the phase is DT0 or ON0 of a normal period.
- R12: When `rst_n` is low at a rising edge, or `en` is low, the phase becomes idle at the next edge with both outputs low. When `en` is high in idle, DT0 starts at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low forces idle |
| dt0_len | input | 12 | Length of dead time 0 in cycles |
| on0_len | input | 12 | Length of on time 0 in cycles |
| dt1_len | input | 12 | Length of dead time 1 in cycles |
| on1_len | input | 12 | Length of on time 1 in cycles |
| flt_a | input | 1 | Fault A, active high, asynchronous |
| flt_b | input | 1 | Fault B, active high, asynchronous |
| drv0 | output | 1 | Drive output 0, high during ON0 |
| drv1 | output | 1 | Drive output 1, high during ON1 |
| phase | output | 3 | Current sequencer state (encoding in R1) |

## Verification
The bench raises fault A inside the guarded half and in the half it does not guard. A design that reacted in both halves would cut a normal ON1 short, and one that lost the jump would keep `drv0` high. It releases fault A in the middle of the forced pair and raises the other fault there. A sequencer that let the release or the other fault cut the pair short would show a shortened DT1 or ON1, or would skip the one-cycle hold. It changes the lengths in the middle of a period, uses zero lengths, and keeps each hold state occupied across several cycles, where an early reload, an off-by-one in the counter or a premature exit would show up in the run lengths of `phase`.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
// Package: cpwm_pkg
// Shared types and helpers for the complementary PWM sequencer.
// Assumes four timed phases, indexed 0..3 in period order.
package cpwm_pkg;

    localparam int unsigned N_TIMED = 4;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_DT0    = 3'd1,
        PH_ON0    = 3'd2,
        PH_DT1    = 3'd3,
        PH_ON1    = 3'd4,
        PH_HOLD_A = 3'd5,
        PH_HOLD_B = 3'd6
    } cpwm_phase_e;

    // Position of a timed phase in the length array (0 for untimed states).
    function automatic logic [1:0] timed_index(input cpwm_phase_e p);
        case (p)
            PH_ON0:  return 2'd1;
            PH_DT1:  return 2'd2;
            PH_ON1:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // True for the four phases that run from the down counter.
    function automatic logic is_timed(input cpwm_phase_e p);
        return (p == PH_DT0) || (p == PH_ON0) || (p == PH_DT1) || (p == PH_ON1);
    endfunction

endpackage

// File: rtl/cpwm_sync.sv
`timescale 1ns/1ps
// Module: cpwm_sync
// Multi-flop synchronizer for a bank of asynchronous, active-high inputs.
// Assumes STAGES >= 2; all flops clear to 0 on synchronous reset.
module cpwm_sync #(
    parameter int unsigned N      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the raw input through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/cpwm_phase_timer.sv
`timescale 1ns/1ps
// Module: cpwm_phase_timer
// Holds the shadow copy of the four phase lengths and times the current phase.
// Shadow lengths reload whenever DT0 is entered; the DT0 length itself is
// taken straight from the input on that entry. A zero length counts as one.
// Assumes start_i pulses for exactly one cycle on each timed-phase entry.
module cpwm_phase_timer
    import cpwm_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  cpwm_phase_e                     enter_i,
    input  logic [N_TIMED-1:0][LEN_W-1:0]   len_i,
    output logic                            expired_o
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [N_TIMED-1:0][LEN_W-1:0] shadow_q;
    logic [LEN_W-1:0]              cnt_q;
    logic [LEN_W-1:0]              sel_len;
    logic [LEN_W-1:0]              load_val;

    // Pick the length of the phase being entered.
    always_comb begin
        if (enter_i == PH_DT0) begin
            sel_len = len_i[0];
        end else begin
            sel_len = shadow_q[timed_index(enter_i)];
        end
        load_val = (sel_len == '0) ? '0 : (sel_len - ONE);
    end

    // Capture all lengths at each DT0 entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (start_i && (enter_i == PH_DT0)) begin
            shadow_q <= len_i;
        end
    end

    // Down counter: load on entry, count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/cpwm_phase_fsm.sv
`timescale 1ns/1ps
// Module: cpwm_phase_fsm
// Phase sequencer with fault retrigger. Fault A acts in DT0/ON0, fault B in
// DT1/ON1. A fault jumps to the opposite pair, which then runs in full
// (a single forced flag masks both faults), followed by a hold state that
// lasts until the fault input is released.
// Assumes flt_a_i / flt_b_i are already synchronized to clk.
module cpwm_phase_fsm
    import cpwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic        flt_a_i,
    input  logic        flt_b_i,
    input  logic        expired_i,
    output cpwm_phase_e phase_o,
    output cpwm_phase_e enter_o,
    output logic        start_o
);

    cpwm_phase_e state_q, state_d;
    logic        forced_q, forced_d;
    logic        jump;
    logic        evt_a, evt_b;

    // Fault events are masked while a forced pair is running.
    assign evt_a = flt_a_i && !forced_q;
    assign evt_b = flt_b_i && !forced_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        jump    = 1'b0;
        if (!en_i) begin
            state_d = PH_IDLE;
        end else begin
            case (state_q)
                PH_IDLE: state_d = PH_DT0;
                PH_DT0: begin
                    if (evt_a) begin
                        state_d = PH_DT1;
                        jump    = 1'b1;
                    end else if (expired_i) begin
                        state_d = PH_ON0;
                    end
                end
                PH_ON0: begin
                    if (evt_a) begin
                        state_d = PH_DT1;
                        jump    = 1'b1;
                    end else if (expired_i) begin
                        state_d = forced_q ? PH_HOLD_B : PH_DT1;
                    end
                end
                PH_DT1: begin
                    if (evt_b) begin
                        state_d = PH_DT0;
                        jump    = 1'b1;
                    end else if (expired_i) begin
                        state_d = PH_ON1;
                    end
                end
                PH_ON1: begin
                    if (evt_b) begin
                        state_d = PH_DT0;
                        jump    = 1'b1;
                    end else if (expired_i) begin
                        state_d = forced_q ? PH_HOLD_A : PH_DT0;
                    end
                end
                PH_HOLD_A: if (!flt_a_i) state_d = PH_DT0;
                PH_HOLD_B: if (!flt_b_i) state_d = PH_DT1;
                default:   state_d = PH_IDLE;
            endcase
        end
    end

    // Forced flag: set by a fault jump, cleared on hold or idle.
    always_comb begin
        if (jump) begin
            forced_d = 1'b1;
        end else if ((state_d == PH_HOLD_A) || (state_d == PH_HOLD_B) ||
                     (state_d == PH_IDLE)) begin
            forced_d = 1'b0;
        end else begin
            forced_d = forced_q;
        end
    end

    // State and forced-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PH_IDLE;
            forced_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            forced_q <= forced_d;
        end
    end

    assign phase_o = state_q;
    assign enter_o = state_d;
    assign start_o = (state_d != state_q) && is_timed(state_d);

endmodule

// File: rtl/cpwm_fault_seq.sv
`timescale 1ns/1ps
// Module: cpwm_fault_seq
// Top level of the complementary PWM sequencer with fault retrigger.
// Synchronizes the two faults, runs the phase sequencer and timer, and
// decodes the two drive outputs from the registered phase.
// Assumes LEN_W-bit lengths in clock cycles; rst_n is synchronous.
module cpwm_fault_seq
    import cpwm_pkg::*;
#(
    parameter int unsigned LEN_W       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LEN_W-1:0] dt0_len,
    input  logic [LEN_W-1:0] on0_len,
    input  logic [LEN_W-1:0] dt1_len,
    input  logic [LEN_W-1:0] on1_len,
    input  logic             flt_a,
    input  logic             flt_b,
    output logic             drv0,
    output logic             drv1,
    output logic [2:0]       phase
);

    logic [1:0]                    flt_sync;
    logic [N_TIMED-1:0][LEN_W-1:0] len_bus;
    logic                          expired;
    logic                          start;
    cpwm_phase_e                   cur_phase;
    cpwm_phase_e                   next_phase;

    assign len_bus = {on1_len, dt1_len, on0_len, dt0_len};

    cpwm_sync #(
        .N      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({flt_b, flt_a}),
        .sync_o  (flt_sync)
    );

    cpwm_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .flt_a_i   (flt_sync[0]),
        .flt_b_i   (flt_sync[1]),
        .expired_i (expired),
        .phase_o   (cur_phase),
        .enter_o   (next_phase),
        .start_o   (start)
    );

    cpwm_phase_timer #(
        .LEN_W (LEN_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .enter_i   (next_phase),
        .len_i     (len_bus),
        .expired_o (expired)
    );

    // Drive outputs decoded from the registered phase only.
    assign drv0  = (cur_phase == PH_ON0);
    assign drv1  = (cur_phase == PH_ON1);
    assign phase = cur_phase;

endmodule

// File: rtl/cpwm_fault_seq_chk.sv
`timescale 1ns/1ps
// Module: cpwm_fault_seq_chk
// Property checker bound to cpwm_fault_seq; observes ports only.
module cpwm_fault_seq_chk
    import cpwm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       flt_a,
    input logic       flt_b,
    input logic       drv0,
    input logic       drv1,
    input logic [2:0] phase
);

    AST_DRV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv0 && drv1)); // R4

    AST_DRV0_IN_ON0: assert property (@(posedge clk) disable iff (!rst_n)
        drv0 |-> (phase == PH_ON0)); // R4

    AST_DRV1_IN_ON1: assert property (@(posedge clk) disable iff (!rst_n)
        drv1 |-> (phase == PH_ON1)); // R4

    AST_DISABLE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((phase == PH_IDLE) && !drv0 && !drv1)); // R12

    AST_IDLE_STARTS_DT0: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (phase == PH_IDLE)) |=> (phase == PH_DT0)); // R12

    AST_ON0_SUCCESSOR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ON0) |=> (phase inside {PH_ON0, PH_DT1, PH_HOLD_B, PH_IDLE})); // R1

    AST_ON1_SUCCESSOR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ON1) |=> (phase inside {PH_ON1, PH_DT0, PH_HOLD_A, PH_IDLE})); // R1

    AST_HOLD_A_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (phase == PH_HOLD_A) && $past(flt_a, 2)) |=> (phase == PH_HOLD_A)); // R7

    AST_HOLD_B_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (phase == PH_HOLD_B) && $past(flt_b, 2)) |=> (phase == PH_HOLD_B)); // R10

endmodule

bind cpwm_fault_seq cpwm_fault_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .flt_a (flt_a),
    .flt_b (flt_b),
    .drv0  (drv0),
    .drv1  (drv1),
    .phase (phase)
);

// File: tb/tb_cpwm_fault_seq.sv
`timescale 1ns/1ps
// Directed bench for cpwm_fault_seq; samples and drives on the falling edge.
module tb_cpwm_fault_seq;

    localparam logic [2:0] IDLE = 3'd0, DT0 = 3'd1, ON0 = 3'd2, DT1 = 3'd3,
                           ON1 = 3'd4, HLA = 3'd5, HLB = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n, en, flt_a, flt_b;
    logic [11:0] dt0_len, on0_len, dt1_len, on1_len;
    logic        drv0, drv1;
    logic [2:0]  phase;

    int n_vec = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cpwm_fault_seq dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .dt0_len(dt0_len), .on0_len(on0_len), .dt1_len(dt1_len), .on1_len(on1_len),
        .flt_a(flt_a), .flt_b(flt_b),
        .drv0(drv0), .drv1(drv1), .phase(phase)
    );

    task automatic step();
        @(negedge clk);
    endtask

    // Compare {phase, drv0, drv1} against the expected phase and its drives.
    task automatic chk_phase(input logic [2:0] ph, input string req);
        logic [4:0] act, exp;
        act = {phase, drv0, drv1};
        exp = {ph, (ph == ON0), (ph == ON1)};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {phase,drv0,drv1} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_run(input logic [2:0] ph, input int len, input string req);
        for (int i = 0; i < len; i++) begin
            chk_phase(ph, req);
            step();
        end
    endtask

    task automatic set_lens(input int a, input int b, input int c, input int d);
        dt0_len = 12'(a); on0_len = 12'(b); dt1_len = 12'(c); on1_len = 12'(d);
    endtask

    // Go idle, load lengths, start; returns at the first DT0 sample.
    task automatic restart(input int a, input int b, input int c, input int d);
        en = 1'b0;
        step();
        set_lens(a, b, c, d);
        en = 1'b1;
        step();
    endtask

    // Every-cycle output safety monitor.
    always @(negedge clk) begin
        if (mon_on) begin
            n_vec++;
            if ((drv0 && drv1) || (drv0 && phase != ON0) || (drv1 && phase != ON1)) begin
                n_bad++;
                $display("FAIL R4: drv0=%b drv1=%b phase=%0d expected exclusive drive in ON phase", drv0, drv1, phase);
            end
        end
    end

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0; flt_a = 1'b0; flt_b = 1'b0;
        set_lens(0, 0, 0, 0);
        repeat (3) step();
        chk_phase(IDLE, "R12 reset");
        rst_n = 1'b1;
        step();
        mon_on = 1'b1;
        expect_run(IDLE, 2, "R12 en low");
    endtask

    task automatic t_normal();
        restart(2, 3, 1, 4);
        expect_run(DT0, 2, "R1 R2");
        expect_run(ON0, 3, "R1 R2");
        expect_run(DT1, 1, "R1 R2");
        expect_run(ON1, 4, "R1 R2");
        expect_run(DT0, 2, "R1");
        expect_run(ON0, 3, "R1");
    endtask

    task automatic t_zero();
        restart(0, 0, 0, 0);
        expect_run(DT0, 1, "R2 zero");
        expect_run(ON0, 1, "R2 zero");
        expect_run(DT1, 1, "R2 zero");
        expect_run(ON1, 1, "R2 zero");
        expect_run(DT0, 1, "R2 zero");
        expect_run(ON0, 1, "R2 zero");
    endtask

    task automatic t_reload();
        restart(2, 3, 1, 4);
        expect_run(DT0, 2, "R3");
        set_lens(1, 1, 3, 2);
        expect_run(ON0, 3, "R3 old length");
        expect_run(DT1, 1, "R3 old length");
        expect_run(ON1, 4, "R3 old length");
        expect_run(DT0, 1, "R3 new length");
        expect_run(ON0, 1, "R3 new length");
        expect_run(DT1, 3, "R3 new length");
        expect_run(ON1, 2, "R3 new length");
    endtask

    task automatic t_fault_a();
        restart(3, 5, 2, 3);
        expect_run(DT0, 3, "R5");
        flt_a = 1'b1;
        expect_run(ON0, 3, "R5 cut short");
        expect_run(DT1, 2, "R5 R6");
        expect_run(ON1, 3, "R6");
        expect_run(HLA, 4, "R7 hold");
        flt_a = 1'b0;
        expect_run(HLA, 3, "R7 release latency");
        expect_run(DT0, 3, "R7 resume");
        expect_run(ON0, 5, "R7 resume");
    endtask

    task automatic t_fault_a_release();
        restart(5, 4, 3, 2);
        flt_a = 1'b1;
        expect_run(DT0, 3, "R5 in DT0");
        flt_a = 1'b0;
        flt_b = 1'b1;
        expect_run(DT1, 3, "R6 full DT1");
        expect_run(ON1, 2, "R6 full ON1");
        expect_run(HLA, 1, "R7 min hold");
        flt_b = 1'b0;
        expect_run(DT0, 5, "R11");
        expect_run(ON0, 4, "R11");
        expect_run(DT1, 3, "R7 normal");
        expect_run(ON1, 2, "R7 normal");
    endtask

    task automatic t_a_ignored();
        restart(3, 5, 2, 6);
        expect_run(DT0, 3, "R8");
        expect_run(ON0, 5, "R8");
        flt_a = 1'b1;
        expect_run(DT1, 2, "R8");
        flt_a = 1'b0;
        expect_run(ON1, 6, "R8 not cut");
        expect_run(DT0, 3, "R8");
    endtask

    task automatic t_fault_b();
        restart(2, 3, 4, 3);
        expect_run(DT0, 2, "R9");
        expect_run(ON0, 3, "R9");
        flt_b = 1'b1;
        expect_run(DT1, 3, "R9 cut short");
        flt_a = 1'b1;
        expect_run(DT0, 2, "R9 forced DT0");
        expect_run(ON0, 3, "R9 forced ON0");
        flt_a = 1'b0;
        expect_run(HLB, 4, "R10 hold");
        flt_b = 1'b0;
        expect_run(HLB, 3, "R10 release latency");
        expect_run(DT1, 4, "R10 resume");
        expect_run(ON1, 3, "R10 resume");
        expect_run(DT0, 2, "R10");
    endtask

    task automatic t_b_ignored();
        restart(4, 5, 2, 2);
        flt_b = 1'b1;
        expect_run(DT0, 2, "R11");
        flt_b = 1'b0;
        expect_run(DT0, 2, "R11 not cut");
        expect_run(ON0, 5, "R11");
        expect_run(DT1, 2, "R11");
        expect_run(ON1, 2, "R11");
        expect_run(DT0, 4, "R11");
    endtask

    task automatic t_enable();
        restart(2, 3, 2, 2);
        expect_run(DT0, 2, "R12");
        en = 1'b0;
        step();
        expect_run(IDLE, 3, "R12 disable");
        en = 1'b1;
        step();
        expect_run(DT0, 2, "R12 restart");
        expect_run(ON0, 3, "R12 restart");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; flt_a = 1'b0; flt_b = 1'b0;
        set_lens(0, 0, 0, 0);
        step();
        t_reset();
        t_normal();
        t_zero();
        t_reload();
        t_fault_a();
        t_fault_a_release();
        t_a_ignored();
        t_fault_b();
        t_b_ignored();
        t_enable();
        finish_run();
    end

endmodule